// File: doc/BRIEF.md
# Configurable DRAM Bank Address Decoder

This block holds the memory-range settings of a host bridge and turns a processor address into a DRAM bank selection. Software reaches it through a simple 32-bit configuration port, addressed by a function number and a dword-aligned byte offset. Through that port it programs a start and an end address for each of eight banks, plus an 8-bit mask that enables the banks. The same port also returns a handful of fixed identification and configuration words.

The lookup side is purely combinational. A 32-bit processor address goes in, and the block returns a hit flag, the index of the bank that claims the address, and the byte offset of the address from that bank's start. The lookup has no flow control: it has no valid/ready pair and no back-pressure, and its result tracks its address input in the same cycle. Configuration writes are registered. Configuration reads are combinational.

Top module: `dram_bank_decoder`

## Requirements
- R1: With function 0, offset 0x00 reads 0x00011057, 0x08 reads 0x06000000, 0xAC reads 0x000C060C, and 0xF0/0xF4/0xF8/0xFC read 0xFF020000/0x00000003/0x00000000/0x00100000. Every other offset that is not a range register or the enable register reads zero.
- R2: With a function number other than 0, every read returns zero and every write is ignored.
- R3: Offsets 0x80 to 0x9C (index = offset bits 4:2) are eight 32-bit range registers that read back exactly as written. Offset 0xA0 stores write-data bits 7:0 as the bank enable mask and reads it back zero-extended. Writes to the fixed-word offsets change nothing.
- R4: Reset clears all range registers and the enable mask, so no address hits. A write is sampled at a rising clock edge, and its effect is visible only after that edge.
- R5: Bank n uses byte lane n mod 4 (bits 8*(n mod 4)+7 : 8*(n mod 4)) of four registers: index n/4 (start low), n/4+2 (start extended), n/4+4 (end low) and n/4+6 (end extended). The start address is {2'b00, ext[1:0], low[7:0], 20'h00000}. Bits 7:2 of an extended byte are ignored.
- R6: The programmed end is built the same way, with bits 19:0 set to all ones. The effective end is the lesser of the programmed end and start + RAM_BYTES − 1.
- R7: A bank is active only when its enable bit is set and start + 0x100000 ≤ effective end. A bank whose programmed window is exactly 1 MB, or whose end lies below its start, never hits.
- R8: An address hits a bank when the bank is active, address bits 31:30 are zero, and start ≤ address ≤ effective end.
- R9: When several banks hit, the lowest-numbered bank is reported. ram_offset equals address − start of that bank. On a miss, bank_idx and ram_offset are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Configuration function number |
| cfg_offset | input | 8 | Configuration byte offset (dword aligned) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| cpu_addr | input | 32 | Processor address to decode |
| bank_hit | output | 1 | Address falls in an active bank |
| bank_idx | output | 3 | Winning bank number |
| ram_offset | output | 32 | Address minus the winning bank's start |

## Verification
The lookup is swept over the first and the last byte of every megabyte of the 30-bit space, plus addresses with bit 30 or bit 31 set, under three bank layouts. The first layout uses disjoint banks, including one clamped by the RAM size, one built from extended bits with junk in the upper bits of the byte, a 1 MB bank and a disabled bank. It separates errors in lane selection, extended-field masking, clamping and the size rule. The second layout has overlapping banks and one bank with an inverted range, so it exposes priority errors. The third has every bank disabled, which shows whether the enable gating works. Configuration tests read the fixed words, try foreign-function accesses and writes to read-only offsets, and check that a write appears only after its clock edge.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int NUM_BANKS = 8;
  localparam int LANES     = 4;
  localparam int RNG_REGS  = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int RIDX_W    = $clog2(RNG_REGS);

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CLASS  = 8'h08;
  localparam logic [7:0] OFS_ENABLE = 8'hA0;
  localparam logic [7:0] OFS_PROC   = 8'hAC;
  localparam logic [7:0] OFS_MC0    = 8'hF0;
  localparam logic [7:0] OFS_MC1    = 8'hF4;
  localparam logic [7:0] OFS_MC2    = 8'hF8;
  localparam logic [7:0] OFS_MC3    = 8'hFC;

  localparam logic [31:0] WORD_ID    = 32'h0001_1057;
  localparam logic [31:0] WORD_CLASS = 32'h0600_0000;
  localparam logic [31:0] WORD_PROC  = 32'h000C_060C;
  localparam logic [31:0] WORD_MC0   = 32'hFF02_0000;
  localparam logic [31:0] WORD_MC1   = 32'h0000_0003;
  localparam logic [31:0] WORD_MC2   = 32'h0000_0000;
  localparam logic [31:0] WORD_MC3   = 32'h0010_0000;

  localparam logic [32:0] MIN_SPAN = 33'h0010_0000;
endpackage

// File: rtl/dbd_cfg_regs.sv
module dbd_cfg_regs
  import dbd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    func,
  input  logic [7:0]                    offset,
  input  logic                          we,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [RNG_REGS-1:0][31:0]     rng_o,
  output logic [NUM_BANKS-1:0]          en_o
);
  logic [RNG_REGS-1:0][31:0] rng_q;
  logic [NUM_BANKS-1:0]      en_q;
  logic                      fn_ok;
  logic                      is_rng;
  logic [RIDX_W-1:0]         ridx;

  assign fn_ok  = (func == 3'd0);
  assign is_rng = (offset[7:5] == 3'b100) && (offset[1:0] == 2'b00);
  assign ridx   = offset[RIDX_W+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng_q <= '0;
      en_q  <= '0;
    end else if (we && fn_ok) begin
      if (is_rng)
        rng_q[ridx] <= wdata;
      else if (offset == OFS_ENABLE)
        en_q <= wdata[NUM_BANKS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (fn_ok) begin
      if (is_rng) begin
        rdata = rng_q[ridx];
      end else begin
        case (offset)
          OFS_ID:     rdata = WORD_ID;
          OFS_CLASS:  rdata = WORD_CLASS;
          OFS_ENABLE: rdata = 32'(en_q);
          OFS_PROC:   rdata = WORD_PROC;
          OFS_MC0:    rdata = WORD_MC0;
          OFS_MC1:    rdata = WORD_MC1;
          OFS_MC2:    rdata = WORD_MC2;
          OFS_MC3:    rdata = WORD_MC3;
          default:    rdata = '0;
        endcase
      end
    end
  end

  assign rng_o = rng_q;
  assign en_o  = en_q;

  // R2: a foreign-function write leaves all stored state untouched
  a_r2_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && func != 3'd0) |=> ($stable(rng_q) && $stable(en_q)));

  // R4: state is empty on the first cycle out of reset
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && rng_q == '0));
endmodule

// File: rtl/dbd_bank_range.sv
module dbd_bank_range
  import dbd_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 32'h0400_0000
) (
  input  logic [7:0]  st_low,
  input  logic [7:0]  st_ext,
  input  logic [7:0]  nd_low,
  input  logic [7:0]  nd_ext,
  input  logic        enable,
  output logic [31:0] start_o,
  output logic [31:0] last_o,
  output logic        active_o
);
  localparam logic [32:0] RAM_W = 33'(RAM_BYTES);

  logic [31:0] prog_end;
  logic [32:0] cap;

  assign start_o  = {2'b00, st_ext[1:0], st_low, 20'h00000};
  assign prog_end = {2'b00, nd_ext[1:0], nd_low, 20'hFFFFF};
  assign cap      = {1'b0, start_o} + RAM_W - 33'd1;
  assign last_o   = ({1'b0, prog_end} < cap) ? prog_end : cap[31:0];
  assign active_o = enable && (({1'b0, start_o} + MIN_SPAN) <= {1'b0, last_o});
endmodule

// File: rtl/dbd_hit_select.sv
module dbd_hit_select
  import dbd_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 32'h0400_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [31:0]                   addr,
  input  logic [NUM_BANKS-1:0][31:0]    starts,
  input  logic [NUM_BANKS-1:0][31:0]    lasts,
  input  logic [NUM_BANKS-1:0]          active,
  output logic                          hit,
  output logic [BANK_W-1:0]             idx,
  output logic [31:0]                   offset
);
  logic [NUM_BANKS-1:0] match;
  logic [BANK_W-1:0]    sel;
  logic                 in_space;

  assign in_space = (addr[31:30] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    assign match[b] = active[b] && in_space &&
                      (addr >= starts[b]) && (addr <= lasts[b]);
  end

  always_comb begin
    sel = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (match[b]) sel = BANK_W'(b);
  end

  assign hit    = |match;
  assign idx    = hit ? sel : '0;
  assign offset = hit ? (addr - starts[sel]) : '0;

  // R8: a hit never comes from outside the decoded 30-bit space
  a_r8_hit_low_space: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (addr[31:30] == 2'b00));

  // R8: the reported bank is an active one and contains the address
  a_r8_hit_active: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (active[idx] && addr <= lasts[idx]));

  // R9: offsets stay inside the installed RAM
  a_r9_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (33'(offset) < 33'(RAM_BYTES)));

  // R9: a miss reports a zero index and offset
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (idx == '0 && offset == '0));
endmodule

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder
  import dbd_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 32'h0400_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_func,
  input  logic [7:0]  cfg_offset,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] cpu_addr,
  output logic        bank_hit,
  output logic [2:0]  bank_idx,
  output logic [31:0] ram_offset
);
  localparam int GRP = NUM_BANKS / LANES;

  logic [RNG_REGS-1:0][31:0]  rng;
  logic [NUM_BANKS-1:0]       en;
  logic [NUM_BANKS-1:0][31:0] starts;
  logic [NUM_BANKS-1:0][31:0] lasts;
  logic [NUM_BANKS-1:0]       active;

  dbd_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .func   (cfg_func),
    .offset (cfg_offset),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .rng_o  (rng),
    .en_o   (en)
  );

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
    localparam int R = n / LANES;
    localparam int L = (n % LANES) * 8;
    dbd_bank_range #(.RAM_BYTES(RAM_BYTES)) u_rng (
      .st_low   (rng[R][L +: 8]),
      .st_ext   (rng[R + GRP][L +: 8]),
      .nd_low   (rng[R + 2*GRP][L +: 8]),
      .nd_ext   (rng[R + 3*GRP][L +: 8]),
      .enable   (en[n]),
      .start_o  (starts[n]),
      .last_o   (lasts[n]),
      .active_o (active[n])
    );
  end

  dbd_hit_select #(.RAM_BYTES(RAM_BYTES)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (cpu_addr),
    .starts (starts),
    .lasts  (lasts),
    .active (active),
    .hit    (bank_hit),
    .idx    (bank_idx),
    .offset (ram_offset)
  );
endmodule

// File: tb/dram_bank_decoder_tb.sv
module dram_bank_decoder_tb_top;
  localparam int unsigned RAM = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_func = '0;
  logic [7:0]  cfg_offset = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        bank_hit;
  logic [2:0]  bank_idx;
  logic [31:0] ram_offset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_rng [8];
  logic [7:0]  m_en;

  always #10 clk = ~clk;

  dram_bank_decoder #(.RAM_BYTES(RAM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_offset(cfg_offset),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_addr(cpu_addr), .bank_hit(bank_hit), .bank_idx(bank_idx),
    .ram_offset(ram_offset)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] f, input logic [7:0] o, input logic [31:0] d);
    @(negedge clk);
    cfg_func = f; cfg_offset = o; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_func = '0;
  endtask

  task automatic cfg_read_check(input string req, input logic [2:0] f, input logic [7:0] o,
                                input logic [31:0] exp);
    cfg_func = f; cfg_offset = o; #1;
    check(req, 64'(cfg_rdata), 64'(exp));
    cfg_func = '0;
  endtask

  task automatic load(input logic [31:0] r [8], input logic [31:0] en_word);
    for (int i = 0; i < 8; i++) begin
      cfg_write(3'd0, 8'h80 + 8'(4 * i), r[i]);
      m_rng[i] = r[i];
    end
    cfg_write(3'd0, 8'hA0, en_word);
    m_en = en_word[7:0];
  endtask

  // Bench model of R5..R9
  task automatic model(input logic [31:0] a, output logic h, output logic [2:0] ix,
                       output logic [31:0] of);
    h = 0; ix = 0; of = 0;
    for (int b = 7; b >= 0; b--) begin
      longint s, e, lim;
      s = (longint'((m_rng[b/4]   >> (8*(b%4))) & 32'hFF) << 20) |
          (longint'((m_rng[b/4+2] >> (8*(b%4))) & 32'h3)  << 28);
      e = (longint'((m_rng[b/4+4] >> (8*(b%4))) & 32'hFF) << 20) |
          (longint'((m_rng[b/4+6] >> (8*(b%4))) & 32'h3)  << 28) | 64'hFFFFF;
      lim = s + longint'(RAM) - 1;
      if (lim < e) e = lim;
      if (m_en[b] && (s + 64'h100000 <= e) && longint'(a) < 64'h4000_0000 &&
          longint'(a) >= s && longint'(a) <= e) begin
        h = 1; ix = 3'(b); of = 32'(longint'(a) - s);
      end
    end
  endtask

  task automatic probe(input string req, input logic [31:0] a);
    logic h; logic [2:0] ix; logic [31:0] of;
    cpu_addr = a; #1;
    model(a, h, ix, of);
    check(req, {31'd0, bank_hit, bank_idx, ram_offset}, {31'd0, h, ix, of});
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 1024; k++) begin
      probe(req, 32'(k) << 20);
      probe(req, (32'(k) << 20) | 32'hFFFFF);
    end
    probe({req, " R8"}, 32'h4000_0000);
    probe({req, " R8"}, 32'h8000_0010);
    probe({req, " R8"}, 32'hC010_0000);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s1 [8];
    logic [31:0] s2 [8];
    logic [31:0] s3 [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset state
    for (int i = 0; i < 8; i++) begin
      cfg_read_check("R4 reset range reg", 3'd0, 8'h80 + 8'(4 * i), 32'h0);
      m_rng[i] = '0;
    end
    cfg_read_check("R4 reset enable", 3'd0, 8'hA0, 32'h0);
    m_en = '0;
    probe("R4 reset no hit", 32'h0000_0000);

    // R1: fixed words and unlisted offsets
    cfg_read_check("R1 id", 3'd0, 8'h00, 32'h0001_1057);
    cfg_read_check("R1 class", 3'd0, 8'h08, 32'h0600_0000);
    cfg_read_check("R1 proc", 3'd0, 8'hAC, 32'h000C_060C);
    cfg_read_check("R1 mc0", 3'd0, 8'hF0, 32'hFF02_0000);
    cfg_read_check("R1 mc1", 3'd0, 8'hF4, 32'h0000_0003);
    cfg_read_check("R1 mc2", 3'd0, 8'hF8, 32'h0000_0000);
    cfg_read_check("R1 mc3", 3'd0, 8'hFC, 32'h0010_0000);
    cfg_read_check("R1 unlisted 04", 3'd0, 8'h04, 32'h0);
    cfg_read_check("R1 unlisted A8", 3'd0, 8'hA8, 32'h0);
    cfg_read_check("R1 unlisted A4", 3'd0, 8'hA4, 32'h0);

    // R3: fixed-word writes discarded
    cfg_write(3'd0, 8'hF0, 32'h1234_5678);
    cfg_read_check("R3 mc0 write discarded", 3'd0, 8'hF0, 32'hFF02_0000);
    cfg_write(3'd0, 8'h00, 32'hDEAD_BEEF);
    cfg_read_check("R3 id write discarded", 3'd0, 8'h00, 32'h0001_1057);

    // R2: foreign function
    cfg_read_check("R2 foreign read id", 3'd1, 8'h00, 32'h0);
    cfg_write(3'd2, 8'h80, 32'hFFFF_FFFF);
    cfg_write(3'd5, 8'hA0, 32'hFF);
    cfg_read_check("R2 foreign write range", 3'd0, 8'h80, 32'h0);
    cfg_read_check("R2 foreign write enable", 3'd0, 8'hA0, 32'h0);

    // R4: write visible only after its clock edge
    @(negedge clk);
    cfg_func = 3'd0; cfg_offset = 8'h84; cfg_wdata = 32'hA5A5_5A5A; cfg_we = 1'b1;
    #1 check("R4 before edge", 64'(cfg_rdata), 64'h0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check("R4 after edge", 64'(cfg_rdata), 64'hA5A5_5A5A);

    // Scenario 1: disjoint banks, clamp, extended bits, 1MB bank, disabled bank
    s1[0] = 32'h0030_1000; s1[1] = 32'h8000_4000;
    s1[2] = 32'h0000_0000; s1[3] = 32'h0000_FD00;
    s1[4] = 32'h003F_1F03; s1[5] = 32'h8000_4100;
    s1[6] = 32'h0000_0000; s1[7] = 32'h0000_FD00;
    load(s1, 32'hABCD_EFA3);
    for (int i = 0; i < 8; i++)
      cfg_read_check("R3 readback", 3'd0, 8'h80 + 8'(4 * i), s1[i]);
    cfg_read_check("R3 enable low byte", 3'd0, 8'hA0, 32'h0000_00A3);
    probe("R6 clamp last byte", 32'h017F_FFFF);
    probe("R6 clamp beyond", 32'h0180_0000);
    probe("R5 extended start", 32'h1400_0000);
    probe("R7 one MB bank", 32'h0800_0000);
    sweep("R5 R6 R7 scenario1");

    // Scenario 2: overlap and inverted range
    s2[0] = 32'h0300_0020; s2[1] = 32'h0;
    s2[2] = 32'h0;         s2[3] = 32'h0;
    s2[4] = 32'h0700_0010; s2[5] = 32'h0005_0000;
    s2[6] = 32'h0;         s2[7] = 32'h0;
    load(s2, 32'h49);
    probe("R9 bank6 below overlap", 32'h0000_1234);
    probe("R9 lowest wins overlap", 32'h0040_0000);
    probe("R7 inverted range", 32'h0200_0000);
    sweep("R9 scenario2");

    // Scenario 3: everything disabled
    s3 = s1;
    load(s3, 32'hFFFF_FF00);
    sweep("R7 scenario3 disabled");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule